// File: doc/BRIEF.md
# Two-Line Pulse-Pair Command Decoder

This block takes commands and serial data over just two asynchronous strobe lines, a start line and an end line, and decodes them in a fast system clock domain. A pulse on one line, with no overlap from the other, is a command: a lone start pulse requests the selected reference, and a lone end pulse requests a return to the RF input. Two pulses that overlap carry one data bit instead. The line that rises first sets the value of that bit.

Each line passes through a synchroniser and then through a width qualifier. An event is classified by a small state machine. Data bits enter a select register of parameterised width, most significant bit first. Commands take effect on the trailing edge of their pulse. A data bit takes effect once both lines have returned low. Every decoded event gives a single-cycle strobe, so the logic downstream sees each request exactly once.

Top module: `pp_cmd_decoder`

## Requirements
- R1: Each line is sampled through SYNC_STAGES flops and then must hold a new level for MIN_HOLD consecutive samples before the decoder acts on it. A pulse shorter than that produces no strobe and leaves `sel_o` unchanged.
- R2: A start pulse that the end line never overlaps produces exactly one `start_cmd_o` pulse one cycle wide. The pulse follows the start line's falling edge at the pin by SYNC_STAGES+MIN_HOLD+1 clock edges.
- R3: An end pulse that the start line never overlaps produces exactly one `end_cmd_o` pulse one cycle wide, on its trailing edge.
- R4: If start rises first and end rises while start is still high, a 1 is shifted in. This gives one `shift_stb_o` pulse and no command strobe.
- R5: If end rises first and start rises while end is still high, a 0 is shifted in. This gives one `shift_stb_o` pulse and no command strobe.
- R6: A shift happens only after both lines are low again. It updates `sel_o` to {sel_o[SEL_W-2:0], bit}, so after four shifts the first bit received is in bit 3 and the last is in bit 0.
- R7: While `rst_n` is low, `sel_o` is all zeros and all three strobes are low.
- R8: A lone pulse never alters `sel_o`. The same lone pulse repeated gives the same strobe again, and nothing toggles.
- R9: At most one of `start_cmd_o`, `end_cmd_o` and `shift_stb_o` is high in any cycle. Each of them is high for one cycle only.
- R10: If both lines rise in the same sample, the event is a pair carrying a 0.
- R11: If the start line falls in the same sample that the end line rises, the result is a start command followed by a separate lone end event. No shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_line | input | 1 | Asynchronous start strobe line |
| end_line | input | 1 | Asynchronous end strobe line |
| sel_o | output | SEL_W | Select register contents |
| shift_stb_o | output | 1 | One-cycle strobe when a data bit is shifted in |
| start_cmd_o | output | 1 | One-cycle start command strobe |
| end_cmd_o | output | 1 | One-cycle end command strobe |

## Verification
The properties assume that the qualified lines change only at sample edges. They also assume that each event finishes before the next one starts. A line that rises again while its partner is still high is treated as part of the same pair. The stimulus drives both lines on the falling clock edge and holds every level for at least eight cycles, well above MIN_HOLD. The only exceptions are the deliberate one-cycle glitches, plus the same-sample rise and fall cases that R10 and R11 define.

// File: rtl/pp_cmd_pkg.sv
package pp_cmd_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_START = 2'd1,
    EV_END   = 2'd2,
    EV_PAIR  = 2'd3
  } ev_state_t;
endpackage

// File: rtl/pp_line_sync.sv
module pp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = line_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/pp_line_filter.sv
module pp_line_filter #(
  parameter int MIN_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (MIN_HOLD < 2) ? 1 : $clog2(MIN_HOLD);
  localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);

  logic          lvl_q, lvl_d, lvl_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differs;

  assign differs = (line_i != lvl_q);

  always_comb begin
    lvl_en = 1'b0;
    lvl_d  = lvl_q;
    cnt_d  = '0;
    if (differs) begin
      if (cnt_q == LAST) begin
        lvl_en = 1'b1;
        lvl_d  = line_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign line_o = lvl_q;
endmodule

// File: rtl/pp_event_fsm.sv
module pp_event_fsm
  import pp_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic start_fire_o,
  output logic end_fire_o,
  output logic shift_fire_o,
  output logic shift_bit_o
);
  ev_state_t state_q, state_d;
  logic      bit_q, bit_d;

  always_comb begin
    state_d      = state_q;
    bit_d        = bit_q;
    start_fire_o = 1'b0;
    end_fire_o   = 1'b0;
    shift_fire_o = 1'b0;
    unique case (state_q)
      EV_IDLE: begin
        if (start_i && end_i) begin
          state_d = EV_PAIR;
          bit_d   = 1'b0;
        end else if (start_i) begin
          state_d = EV_START;
        end else if (end_i) begin
          state_d = EV_END;
        end
      end
      EV_START: begin
        if (!start_i) begin
          start_fire_o = 1'b1;
          state_d      = end_i ? EV_END : EV_IDLE;
        end else if (end_i) begin
          state_d = EV_PAIR;
          bit_d   = 1'b1;
        end
      end
      EV_END: begin
        if (!end_i) begin
          end_fire_o = 1'b1;
          state_d    = start_i ? EV_START : EV_IDLE;
        end else if (start_i) begin
          state_d = EV_PAIR;
          bit_d   = 1'b0;
        end
      end
      EV_PAIR: begin
        if (!start_i && !end_i) begin
          shift_fire_o = 1'b1;
          state_d      = EV_IDLE;
        end
      end
      default: state_d = EV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EV_IDLE;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  assign shift_bit_o = bit_q;
endmodule

// File: rtl/pp_shift_reg.sv
module pp_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] data_q, data_d;

  always_comb data_d = {data_q[WIDTH-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (shift_en) data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/pp_cmd_decoder.sv
module pp_cmd_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 2,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_line,
  input  logic             end_line,
  output logic [SEL_W-1:0] sel_o,
  output logic             shift_stb_o,
  output logic             start_cmd_o,
  output logic             end_cmd_o
);
  localparam int NLINES = 2;

  logic       rst_meta_q, rst_sync_n;
  logic [NLINES-1:0] raw_lines, sync_lines, flt_lines;
  logic       start_flt, end_flt;
  logic       start_fire, end_fire, shift_fire, shift_bit;
  logic [2:0] stb_q, stb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign raw_lines = {end_line, start_line};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      pp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_sync_n),
        .line_i(raw_lines[g]), .line_o(sync_lines[g])
      );
      pp_line_filter #(.MIN_HOLD(MIN_HOLD)) u_filt (
        .clk(clk), .rst_n(rst_sync_n),
        .line_i(sync_lines[g]), .line_o(flt_lines[g])
      );
    end
  endgenerate

  assign start_flt = flt_lines[0];
  assign end_flt   = flt_lines[1];

  pp_event_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(start_flt), .end_i(end_flt),
    .start_fire_o(start_fire), .end_fire_o(end_fire),
    .shift_fire_o(shift_fire), .shift_bit_o(shift_bit)
  );

  pp_shift_reg #(.WIDTH(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_en(shift_fire), .bit_i(shift_bit), .data_o(sel_o)
  );

  always_comb stb_d = {shift_fire, end_fire, start_fire};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stb_q <= '0;
    else             stb_q <= stb_d;
  end

  assign start_cmd_o = stb_q[0];
  assign end_cmd_o   = stb_q[1];
  assign shift_stb_o = stb_q[2];
endmodule

// File: rtl/pp_cmd_checker.sv
module pp_cmd_checker #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_flt,
  input logic             end_flt,
  input logic [SEL_W-1:0] sel_o,
  input logic             shift_stb_o,
  input logic             start_cmd_o,
  input logic             end_cmd_o
);
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_cmd_o, end_cmd_o, shift_stb_o}));

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd_o |=> !start_cmd_o);

  assert_start_trailing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd_o |-> !$past(start_flt));

  assert_end_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd_o |-> !$past(end_flt));

  assert_shift_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb_o |-> (!$past(start_flt) && !$past(end_flt)));

  assert_shift_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb_o |-> (sel_o[SEL_W-1:1] == $past(sel_o[SEL_W-2:0])));

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_stb_o |-> $stable(sel_o));
endmodule

bind pp_cmd_decoder pp_cmd_checker #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_flt(start_flt), .end_flt(end_flt),
  .sel_o(sel_o), .shift_stb_o(shift_stb_o),
  .start_cmd_o(start_cmd_o), .end_cmd_o(end_cmd_o)
);

// File: tb/pp_cmd_decoder_bench.sv
module pp_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_STAGES = 2;
  localparam int MIN_HOLD = 2;
  localparam int SEL_W = 4;
  localparam int LAT = SYNC_STAGES + MIN_HOLD + 1;
  localparam int NVEC = 10;
  // entry: [5:4] kind (0 lone start, 1 lone end, 2 pair bit 1, 3 pair bit 0), [3:0] sel after
  localparam logic [5:0] VEC [NVEC] = '{
    {2'd2, 4'b0001}, {2'd3, 4'b0010}, {2'd2, 4'b0101}, {2'd2, 4'b1011},
    {2'd0, 4'b1011}, {2'd1, 4'b1011}, {2'd1, 4'b1011}, {2'd3, 4'b0110},
    {2'd3, 4'b1100}, {2'd0, 4'b1100}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_line, end_line;
  logic [SEL_W-1:0] sel_o;
  logic shift_stb_o, start_cmd_o, end_cmd_o;

  int n_checks = 0;
  int n_errors = 0;
  int n_start = 0, n_end = 0, n_shift = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_cmd_decoder #(.SYNC_STAGES(SYNC_STAGES), .MIN_HOLD(MIN_HOLD), .SEL_W(SEL_W))
    u_pp_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .start_line(start_line), .end_line(end_line),
      .sel_o(sel_o), .shift_stb_o(shift_stb_o),
      .start_cmd_o(start_cmd_o), .end_cmd_o(end_cmd_o)
    );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (start_cmd_o) n_start++;
      if (end_cmd_o)   n_end++;
      if (shift_stb_o) n_shift++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lone(input bit is_start);
    if (is_start) start_line = 1'b1; else end_line = 1'b1;
    idle(10);
    if (is_start) start_line = 1'b0; else end_line = 1'b0;
    idle(20);
  endtask

  task automatic pair(input bit start_first);
    if (start_first) start_line = 1'b1; else end_line = 1'b1;
    idle(8);
    if (start_first) end_line = 1'b1; else start_line = 1'b1;
    idle(8);
    if (start_first) start_line = 1'b0; else end_line = 1'b0;
    idle(8);
    if (start_first) end_line = 1'b0; else start_line = 1'b0;
    idle(20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int s0, e0, h0;
    rst_n = 1'b0;
    start_line = 1'b0;
    end_line = 1'b0;
    idle(4);
    chk("R7 reset sel", int'(sel_o), 0);
    chk("R7 reset strobes", int'({start_cmd_o, end_cmd_o, shift_stb_o}), 0);
    rst_n = 1'b1;
    idle(6);

    for (int i = 0; i < NVEC; i++) begin
      s0 = n_start; e0 = n_end; h0 = n_shift;
      case (VEC[i][5:4])
        2'd0: lone(1'b1);
        2'd1: lone(1'b0);
        2'd2: pair(1'b1);
        default: pair(1'b0);
      endcase
      chk("R6 sel after event", int'(sel_o), int'(VEC[i][3:0]));
      chk("R2 start count", n_start - s0, (VEC[i][5:4] == 2'd0) ? 1 : 0);
      chk("R3 R8 end count", n_end - e0, (VEC[i][5:4] == 2'd1) ? 1 : 0);
      chk("R4 R5 shift count", n_shift - h0, (VEC[i][5:4] >= 2'd2) ? 1 : 0);
    end

    // R1: one-cycle glitches on either line are dropped
    s0 = n_start; e0 = n_end; h0 = n_shift;
    start_line = 1'b1; idle(1); start_line = 1'b0; idle(20);
    end_line = 1'b1; idle(1); end_line = 1'b0; idle(20);
    chk("R1 glitch strobes", (n_start - s0) + (n_end - e0) + (n_shift - h0), 0);
    chk("R1 glitch sel", int'(sel_o), 'b1100);

    // R2: exact latency from trailing edge, one cycle wide
    start_line = 1'b1; idle(10);
    start_line = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 not early", int'(start_cmd_o), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 on time", int'(start_cmd_o), 1);
    @(posedge clk); @(negedge clk);
    chk("R9 one cycle", int'(start_cmd_o), 0);
    idle(20);

    // R10: simultaneous rise is a pair carrying 0
    s0 = n_start; e0 = n_end; h0 = n_shift;
    start_line = 1'b1; end_line = 1'b1; idle(10);
    start_line = 1'b0; end_line = 1'b0; idle(20);
    chk("R10 sel", int'(sel_o), 'b1000);
    chk("R10 shift count", n_shift - h0, 1);
    chk("R10 commands", (n_start - s0) + (n_end - e0), 0);

    // R11: start falls as end rises -> start command then lone end
    s0 = n_start; e0 = n_end; h0 = n_shift;
    start_line = 1'b1; idle(10);
    start_line = 1'b0; end_line = 1'b1; idle(10);
    end_line = 1'b0; idle(20);
    chk("R11 start count", n_start - s0, 1);
    chk("R11 end count", n_end - e0, 1);
    chk("R11 no shift", n_shift - h0, 0);
    chk("R11 sel", int'(sel_o), 'b1000);

    // R7: reset mid-run clears the register
    rst_n = 1'b0; idle(2);
    chk("R7 mid reset sel", int'(sel_o), 0);
    chk("R7 mid reset strobes", int'({start_cmd_o, end_cmd_o, shift_stb_o}), 0);
    rst_n = 1'b1; idle(6);
    pair(1'b1);
    chk("R4 after reset", int'(sel_o), 'b0001);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule